// File: doc/BRIEF.md
# ECC Memory Controller Register File

This block is the control and status register file of an ECC DRAM controller. A simple request bus reads and writes nine 32-bit registers selected by word index (byte address shifted right by two). The registers are an enable word, a delay word, a fault status word, a video configuration word, two fault address words, a diagnostic word, and two event counters. Only full-width accesses reach these registers. A build-time parameter selects one of three controller variants. The variant sets the enable register's write mask, which bits survive a soft reset, and whether a small byte-wide diagnostic window exists.

An error-capture strobe from the ECC datapath loads the fault status fields and the physical fault address into the status and address registers, and drives a level interrupt. A second error that arrives while an error flag is still set does not overwrite the first capture. It sets a multiple-error flag instead. Software clears the interrupt by writing the status register.

Two resets are provided. The asynchronous `rst_ni` brings every register to its power-on value. The synchronous `srst_i` applies the variant's retention rules to the enable register and sets the other registers to their reset values.

Top module: `memctl_csr`

## Requirements
- R1: After `rst_ni` the enable word reads the variant code in bits 31:28 with all other bits zero. The delay word reads 0x00000020 and fault address 0 reads 0x07C00000. Every other register reads zero, and `irq_o` and `rvalid_o` are low.
- R2: A read request raises `rvalid_o` for exactly the following cycle, with the data on `rdata_o`. The register index is `req_addr_i[7:2]`: 0 enable, 1 delay, 2 status, 3 video, 4 fault address 0, 5 fault address 1, 6 diagnostic, 7 event 0, 8 event 1. Indices 9 and above read zero.
- R3: On variant 0 an enable write stores `wdata & 0x00000103`. On variants 1 and 2 it stores `wdata & 0x00000BFF` and keeps bits 31:24, which still hold the variant code.
- R4: A delay write stores the written value with bit 31 forced to zero.
- R5: Bus writes to the two fault address registers have no effect.
- R6: A register access whose byte enables `req_be_i` are not 4'hF is ignored. A write of this kind changes nothing, and a read of this kind returns zero (with `rvalid_o`).
- R7: A status write stores the full written value and drops `irq_o` in the next cycle, unless an interrupting capture happens in the same cycle.
- R8: An error strobe arriving while status bits 0 and 3 are both clear does three things. It loads status bits 15:0 as {syndrome[7:0], doubleword[3:0], uncorrectable at bit 3, 2'b00, correctable at bit 0}. It loads fault address 0 bits 3:0 with address bits 35:32, and fault address 1 with address bits 31:0.
- R9: An error strobe arriving while status bit 0 or bit 3 is set does three things. It sets bit 16, ORs its own flag bit (3 for uncorrectable, 0 for correctable) into the status word, and leaves the syndrome, the doubleword index and both fault address words unchanged.
- R10: `irq_o` goes high in the cycle after an uncorrectable strobe. After a correctable strobe it goes high only when enable bits 0 and 1 are both set.
- R11: When an error strobe and a status write fall in the same cycle, the capture is applied on top of the written value, and the interrupt rule of R10 takes priority over the clear of R7.
- R12: `srst_i` reduces the enable word to bit 8 on variant 0. On the other variants it keeps bits 31:24, 11 and 9:2. It sets the other eight registers to their R1 values and clears `irq_o`. It leaves the diagnostic window contents unchanged.
- R13: With `diag_sel_i` high, variant 0 has a 4-byte window indexed by `req_addr_i[1:0]`. The window is accessed only when exactly one byte enable is set; it writes `wdata[7:0]` and reads back in `rdata_o[7:0]`. On variants 1 and 2 window reads return zero and window writes are ignored.
- R14: The video, diagnostic, event 0 and event 1 registers each store a full 32-bit value independently, and event 1 has its own storage at index 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| srst_i | input | 1 | Synchronous soft reset with retention |
| req_valid_i | input | 1 | Bus request strobe |
| req_write_i | input | 1 | 1 write, 0 read |
| diag_sel_i | input | 1 | Selects the byte diagnostic window |
| req_addr_i | input | ADDR_W | Byte address |
| req_be_i | input | 4 | Byte enables |
| req_wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| err_valid_i | input | 1 | Error capture strobe |
| err_uncorr_i | input | 1 | 1 uncorrectable, 0 correctable |
| err_dw_i | input | 4 | Doubleword index of the fault |
| err_synd_i | input | 8 | Syndrome |
| err_paddr_i | input | 36 | Physical fault address |
| irq_o | output | 1 | Fault interrupt, level |

## Verification
Writes, error strobes and soft resets take effect at the clock edge that samples them. Their register and interrupt results are therefore due one cycle later, and read data is due in the cycle after the read request. The bench drives every stimulus on a falling edge and removes it on the next falling edge. At that point it checks `irq_o`, and for reads `rvalid_o` and `rdata_o`, exactly one rising edge after the stimulus. Register contents are observed through reads issued afterwards. Three instances, one per variant, share the same bus, and each is compared against its own bench model.

// File: rtl/memctl_csr_pkg.sv
package memctl_csr_pkg;
  localparam int DW         = 32;
  localparam int NREGS      = 9;
  localparam int DIAG_BYTES = 4;
  localparam int PA_W       = 36;
  localparam int PLAIN_N    = 4;

  typedef enum logic [3:0] {
    IDX_EN   = 4'd0,
    IDX_DLY  = 4'd1,
    IDX_STS  = 4'd2,
    IDX_VID  = 4'd3,
    IDX_FA0  = 4'd4,
    IDX_FA1  = 4'd5,
    IDX_DIAG = 4'd6,
    IDX_EVT0 = 4'd7,
    IDX_EVT1 = 4'd8
  } reg_idx_e;

  localparam logic [DW-1:0] DLY_RST   = 32'h0000_0020;
  localparam logic [DW-1:0] DLY_WMASK = 32'h7FFF_FFFF;
  localparam logic [DW-1:0] FA0_RST   = 32'h07C0_0000;
  localparam logic [DW-1:0] CODE_MASK = 32'hFF00_0000;

  localparam int STS_CE = 0;
  localparam int STS_UE = 3;
  localparam int STS_ME = 16;

  function automatic logic [DW-1:0] en_wmask(int v);
    return (v == 0) ? 32'h0000_0103 : 32'h0000_0BFF;
  endfunction

  function automatic logic [DW-1:0] en_keep(int v);
    return (v == 0) ? 32'h0000_0100 : 32'hFF00_0BFC;
  endfunction

  function automatic logic [DW-1:0] en_por(int v);
    logic [3:0] c;
    c = 4'(v);
    return {c, 28'h0};
  endfunction

  // plain storage slot -> register index
  function automatic int plain_idx(int k);
    case (k)
      0:       return int'(IDX_VID);
      1:       return int'(IDX_DIAG);
      2:       return int'(IDX_EVT0);
      default: return int'(IDX_EVT1);
    endcase
  endfunction
endpackage

// File: rtl/memctl_enable_reg.sv
module memctl_enable_reg
  import memctl_csr_pkg::*;
#(
  parameter int VARIANT = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          srst_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] en_o
);
  localparam logic [DW-1:0] WMASK = en_wmask(VARIANT);
  localparam logic [DW-1:0] KEEP  = en_keep(VARIANT);
  localparam logic [DW-1:0] POR   = en_por(VARIANT);

  logic [DW-1:0] en_q, wr_val;

  generate
    if (VARIANT == 0) begin : g_v0
      assign wr_val = wdata_i & WMASK;
    end else begin : g_vn
      assign wr_val = (en_q & CODE_MASK) | (wdata_i & WMASK);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_q <= POR;
    else if (srst_i) en_q <= en_q & KEEP;
    else if (we_i)   en_q <= wr_val;
  end

  assign en_o = en_q;

  a_r3_code_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q[31:28] == POR[31:28]);

  a_r3_masked_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !srst_i) |=> ((en_q & ~(WMASK | CODE_MASK)) == '0));

  a_r12_retention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> ((en_q & ~KEEP) == '0));
endmodule

// File: rtl/memctl_fault_capture.sv
module memctl_fault_capture
  import memctl_csr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            srst_i,
  input  logic            sts_we_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            chk_en_i,
  input  logic            ce_irq_en_i,
  input  logic            err_valid_i,
  input  logic            err_uncorr_i,
  input  logic [3:0]      err_dw_i,
  input  logic [7:0]      err_synd_i,
  input  logic [PA_W-1:0] err_paddr_i,
  output logic [DW-1:0]   status_o,
  output logic [DW-1:0]   fault0_o,
  output logic [DW-1:0]   fault1_o,
  output logic            irq_o
);
  logic [DW-1:0] status_q, fault0_q, fault1_q;
  logic [DW-1:0] base, status_d, fault0_d, fault1_d;
  logic          irq_q, irq_d, pending, raise;

  assign base    = sts_we_i ? wdata_i : status_q;
  assign pending = base[STS_CE] | base[STS_UE];
  assign raise   = err_valid_i & (err_uncorr_i | (chk_en_i & ce_irq_en_i));

  always_comb begin
    status_d = base;
    fault0_d = fault0_q;
    fault1_d = fault1_q;
    if (err_valid_i) begin
      if (pending) begin
        status_d[STS_ME] = 1'b1;
        if (err_uncorr_i) status_d[STS_UE] = 1'b1;
        else              status_d[STS_CE] = 1'b1;
      end else begin
        status_d[15:0] = {err_synd_i, err_dw_i, err_uncorr_i, 2'b00, ~err_uncorr_i};
        fault0_d[3:0]  = err_paddr_i[PA_W-1:DW];
        fault1_d       = err_paddr_i[DW-1:0];
      end
    end
  end

  always_comb begin
    irq_d = irq_q;
    if (raise)         irq_d = 1'b1;
    else if (sts_we_i) irq_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      fault0_q <= FA0_RST;
      fault1_q <= '0;
      irq_q    <= 1'b0;
    end else if (srst_i) begin
      status_q <= '0;
      fault0_q <= FA0_RST;
      fault1_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      fault0_q <= fault0_d;
      fault1_q <= fault1_d;
      irq_q    <= irq_d;
    end
  end

  assign status_o = status_q;
  assign fault0_o = fault0_q;
  assign fault1_o = fault1_q;
  assign irq_o    = irq_q;

  a_r5_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_valid_i && !srst_i) |=> ($stable(fault0_q) && $stable(fault1_q)));

  a_r7_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_we_i && !err_valid_i) |=> (!irq_o && status_q == $past(wdata_i)));

  a_r9_multi_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_valid_i && !sts_we_i && !srst_i && (status_q[STS_CE] || status_q[STS_UE]))
      |=> (status_q[STS_ME] && $stable(fault1_q)));

  a_r10_ue_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_valid_i && err_uncorr_i && !srst_i) |=> irq_o);

  a_r10_ce_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_valid_i && !err_uncorr_i && !(chk_en_i && ce_irq_en_i) && !irq_o && !srst_i)
      |=> !irq_o);
endmodule

// File: rtl/memctl_diag_window.sv
module memctl_diag_window
  import memctl_csr_pkg::*;
#(
  parameter int BYTES = DIAG_BYTES
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [$clog2(BYTES)-1:0] idx_i,
  input  logic [7:0]               wdata_i,
  output logic [7:0]               rdata_o
);
  logic [7:0] mem_q [BYTES];

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      mem_q[b] <= '0;
      else if (we_i && idx_i == ($clog2(BYTES))'(b))   mem_q[b] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];

  a_r13_byte_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem_q[$past(idx_i)] == $past(wdata_i)));
endmodule

// File: rtl/memctl_csr.sv
module memctl_csr
  import memctl_csr_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int ADDR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              diag_sel_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [3:0]        req_be_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              rvalid_o,
  output logic [DW-1:0]     rdata_o,
  input  logic              err_valid_i,
  input  logic              err_uncorr_i,
  input  logic [3:0]        err_dw_i,
  input  logic [7:0]        err_synd_i,
  input  logic [PA_W-1:0]   err_paddr_i,
  output logic              irq_o
);
  localparam int  IDX_W    = ADDR_W - 2;
  localparam int  DIAG_AW  = $clog2(DIAG_BYTES);
  localparam bit  HAS_DIAG = (VARIANT == 0);

  logic [IDX_W-1:0] idx;
  logic             full_be, one_be, reg_acc, reg_we, diag_acc, rd_req;
  logic [DW-1:0]    en_q, dly_q, sts_q, fa0_q, fa1_q, rd_d, rdata_q;
  logic [DW-1:0]    plain_q [PLAIN_N];
  logic [7:0]       diag_rd;
  logic             rvalid_q;

  assign idx      = req_addr_i[ADDR_W-1:2];
  assign full_be  = (req_be_i == 4'hF);
  assign one_be   = ($countones(req_be_i) == 1);
  assign reg_acc  = req_valid_i && !diag_sel_i && full_be;
  assign reg_we   = reg_acc && req_write_i;
  assign diag_acc = req_valid_i && diag_sel_i && one_be && HAS_DIAG;
  assign rd_req   = req_valid_i && !req_write_i;

  function automatic logic hit(logic [IDX_W-1:0] i, reg_idx_e r);
    return i == IDX_W'(r);
  endfunction

  memctl_enable_reg #(.VARIANT(VARIANT)) u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .srst_i  (srst_i),
    .we_i    (reg_we && hit(idx, IDX_EN)),
    .wdata_i (req_wdata_i),
    .en_o    (en_q)
  );

  memctl_fault_capture u_fault (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .srst_i       (srst_i),
    .sts_we_i     (reg_we && hit(idx, IDX_STS)),
    .wdata_i      (req_wdata_i),
    .chk_en_i     (en_q[0]),
    .ce_irq_en_i  (en_q[1]),
    .err_valid_i  (err_valid_i),
    .err_uncorr_i (err_uncorr_i),
    .err_dw_i     (err_dw_i),
    .err_synd_i   (err_synd_i),
    .err_paddr_i  (err_paddr_i),
    .status_o     (sts_q),
    .fault0_o     (fa0_q),
    .fault1_o     (fa1_q),
    .irq_o        (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          dly_q <= DLY_RST;
    else if (srst_i)                      dly_q <= DLY_RST;
    else if (reg_we && hit(idx, IDX_DLY)) dly_q <= req_wdata_i & DLY_WMASK;
  end

  for (genvar k = 0; k < PLAIN_N; k++) begin : g_plain
    localparam int PIDX = plain_idx(k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 plain_q[k] <= '0;
      else if (srst_i)                             plain_q[k] <= '0;
      else if (reg_we && idx == IDX_W'(PIDX))      plain_q[k] <= req_wdata_i;
    end
  end

  generate
    if (HAS_DIAG) begin : g_diag
      memctl_diag_window #(.BYTES(DIAG_BYTES)) u_diag (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (diag_acc && req_write_i),
        .idx_i   (req_addr_i[DIAG_AW-1:0]),
        .wdata_i (req_wdata_i[7:0]),
        .rdata_o (diag_rd)
      );
    end else begin : g_nodiag
      assign diag_rd = '0;
    end
  endgenerate

  always_comb begin
    rd_d = '0;
    if (diag_acc) begin
      rd_d = {24'h0, diag_rd};
    end else if (reg_acc) begin
      case (idx)
        IDX_W'(IDX_EN):   rd_d = en_q;
        IDX_W'(IDX_DLY):  rd_d = dly_q;
        IDX_W'(IDX_STS):  rd_d = sts_q;
        IDX_W'(IDX_VID):  rd_d = plain_q[0];
        IDX_W'(IDX_FA0):  rd_d = fa0_q;
        IDX_W'(IDX_FA1):  rd_d = fa1_q;
        IDX_W'(IDX_DIAG): rd_d = plain_q[1];
        IDX_W'(IDX_EVT0): rd_d = plain_q[2];
        IDX_W'(IDX_EVT1): rd_d = plain_q[3];
        default:          rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_req;
      rdata_q  <= rd_req ? rd_d : '0;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;

  a_r2_rvalid_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rvalid_o);

  a_r2_rvalid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rvalid_o);

  a_r4_dly_bit31: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we && hit(idx, IDX_DLY)) |=> !dly_q[31]);

  a_r6_partial_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && !diag_sel_i && !full_be) |=> (rdata_o == '0));

  generate
    if (!HAS_DIAG) begin : g_chk_nodiag
      a_r13_no_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_req && diag_sel_i) |=> (rdata_o == '0));
    end
  endgenerate
endmodule

// File: tb/memctl_csr_test.sv
`timescale 1ns/1ps
module memctl_csr_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0, srst = 1'b0;
  logic        rv, wr, dsel;
  logic [7:0]  addr;
  logic [3:0]  be;
  logic [31:0] wd;
  logic        ev, eu;
  logic [3:0]  edw;
  logic [7:0]  esy;
  logic [35:0] epa;
  logic        rvl [3];
  logic [31:0] rdt [3];
  logic        irq [3];

  int total = 0, bad = 0;
  logic [31:0] m [3][9];
  logic        mirq [3];
  logic [7:0]  md [4];

  always #2 clk = ~clk;

  memctl_csr #(.VARIANT(0)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .srst_i(srst), .req_valid_i(rv), .req_write_i(wr),
    .diag_sel_i(dsel), .req_addr_i(addr), .req_be_i(be), .req_wdata_i(wd),
    .rvalid_o(rvl[0]), .rdata_o(rdt[0]), .err_valid_i(ev), .err_uncorr_i(eu),
    .err_dw_i(edw), .err_synd_i(esy), .err_paddr_i(epa), .irq_o(irq[0]));
  memctl_csr #(.VARIANT(1)) uut_v1 (
    .clk_i(clk), .rst_ni(rst_ni), .srst_i(srst), .req_valid_i(rv), .req_write_i(wr),
    .diag_sel_i(dsel), .req_addr_i(addr), .req_be_i(be), .req_wdata_i(wd),
    .rvalid_o(rvl[1]), .rdata_o(rdt[1]), .err_valid_i(ev), .err_uncorr_i(eu),
    .err_dw_i(edw), .err_synd_i(esy), .err_paddr_i(epa), .irq_o(irq[1]));
  memctl_csr #(.VARIANT(2)) uut_v2 (
    .clk_i(clk), .rst_ni(rst_ni), .srst_i(srst), .req_valid_i(rv), .req_write_i(wr),
    .diag_sel_i(dsel), .req_addr_i(addr), .req_be_i(be), .req_wdata_i(wd),
    .rvalid_o(rvl[2]), .rdata_o(rdt[2]), .err_valid_i(ev), .err_uncorr_i(eu),
    .err_dw_i(edw), .err_synd_i(esy), .err_paddr_i(epa), .irq_o(irq[2]));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---- reference model ----
  task automatic model_por();
    for (int v = 0; v < 3; v++) begin
      m[v][0] = {v[3:0], 28'h0};
      m[v][1] = 32'h20;
      m[v][2] = 0; m[v][3] = 0;
      m[v][4] = 32'h07C0_0000;
      m[v][5] = 0; m[v][6] = 0; m[v][7] = 0; m[v][8] = 0;
      mirq[v] = 1'b0;
    end
    for (int b = 0; b < 4; b++) md[b] = 8'h0;
  endtask

  task automatic model_srst();
    for (int v = 0; v < 3; v++) begin
      m[v][0] = m[v][0] & ((v == 0) ? 32'h0000_0100 : 32'hFF00_0BFC);
      m[v][1] = 32'h20;
      m[v][2] = 0; m[v][3] = 0;
      m[v][4] = 32'h07C0_0000;
      m[v][5] = 0; m[v][6] = 0; m[v][7] = 0; m[v][8] = 0;
      mirq[v] = 1'b0;
    end
  endtask

  task automatic model_write(input int idx, input logic [31:0] d);
    for (int v = 0; v < 3; v++) begin
      case (idx)
        0: m[v][0] = (v == 0) ? (d & 32'h103) : ((m[v][0] & 32'hFF00_0000) | (d & 32'hBFF));
        1: m[v][1] = d & 32'h7FFF_FFFF;
        2: begin m[v][2] = d; mirq[v] = 1'b0; end
        3, 6, 7, 8: m[v][idx] = d;
        default: ;
      endcase
    end
  endtask

  task automatic model_capture(input bit u, input logic [3:0] dw, input logic [7:0] sy, input logic [35:0] pa);
    for (int v = 0; v < 3; v++) begin
      if (m[v][2][0] || m[v][2][3]) begin
        m[v][2][16] = 1'b1;
        if (u) m[v][2][3] = 1'b1; else m[v][2][0] = 1'b1;
      end else begin
        m[v][2][15:0] = {sy, dw, u, 2'b00, ~u};
        m[v][4][3:0]  = pa[35:32];
        m[v][5]       = pa[31:0];
      end
      if (u || (m[v][0][0] && m[v][0][1])) mirq[v] = 1'b1;
    end
  endtask

  function automatic logic [31:0] exp_rd(input int v, input logic [7:0] a, input logic [3:0] b, input bit ds);
    int i;
    if (ds) return (v == 0 && $countones(b) == 1) ? {24'h0, md[a[1:0]]} : 32'h0;
    if (b != 4'hF) return 32'h0;
    i = int'(a[7:2]);
    return (i < 9) ? m[v][i] : 32'h0;
  endfunction

  // ---- stimulus ----
  task automatic idle();
    rv = 0; wr = 0; dsel = 0; addr = 0; be = 4'hF; wd = 0;
    ev = 0; eu = 0; edw = 0; esy = 0; epa = 0;
  endtask

  task automatic check_irq(input string tag);
    for (int v = 0; v < 3; v++) chk(irq[v] === mirq[v], tag, 32'(irq[v]), 32'(mirq[v]));
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b, input bit ds, input string tag);
    @(negedge clk);
    rv = 1; wr = 1; addr = a; wd = d; be = b; dsel = ds;
    @(negedge clk);
    idle();
    if (!ds && b == 4'hF && int'(a[7:2]) < 9) model_write(int'(a[7:2]), d);
    if (ds && $countones(b) == 1) md[a[1:0]] = d[7:0];
    check_irq(tag);
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [3:0] b, input bit ds, input string tag);
    @(negedge clk);
    rv = 1; wr = 0; addr = a; be = b; dsel = ds;
    @(negedge clk);
    idle();
    for (int v = 0; v < 3; v++) begin
      chk(rvl[v] === 1'b1, {tag, " rvalid"}, 32'(rvl[v]), 32'h1);
      chk(rdt[v] === exp_rd(v, a, b, ds), tag, rdt[v], exp_rd(v, a, b, ds));
    end
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 9; i++) bus_read(8'(i * 4), 4'hF, 1'b0, tag);
  endtask

  task automatic err_pulse(input bit u, input logic [3:0] dw, input logic [7:0] sy, input logic [35:0] pa,
                           input bit with_wr, input logic [31:0] d, input string tag);
    @(negedge clk);
    ev = 1; eu = u; edw = dw; esy = sy; epa = pa;
    if (with_wr) begin rv = 1; wr = 1; addr = 8'h08; be = 4'hF; wd = d; end
    @(negedge clk);
    idle();
    if (with_wr) model_write(2, d);
    model_capture(u, dw, sy, pa);
    check_irq(tag);
  endtask

  task automatic soft_reset(input string tag);
    @(negedge clk); srst = 1;
    @(negedge clk); srst = 0;
    model_srst();
    check_irq(tag);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240917));
    idle();
    model_por();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    check_irq("R1 irq");
    for (int v = 0; v < 3; v++) chk(rvl[v] === 1'b0, "R1 rvalid", 32'(rvl[v]), 32'h0);
    read_all("R1 reset value");
    // R2 unmapped indices
    for (int i = 9; i < 16; i++) bus_read(8'(i * 4), 4'hF, 1'b0, "R2 unmapped");
    // R3 enable masks
    bus_write(8'h00, 32'hFFFF_FFFF, 4'hF, 0, "R3");
    bus_read(8'h00, 4'hF, 0, "R3 enable all ones");
    bus_write(8'h00, 32'h0, 4'hF, 0, "R3");
    bus_read(8'h00, 4'hF, 0, "R3 enable zero");
    // R4 delay
    bus_write(8'h04, 32'hFFFF_FFFF, 4'hF, 0, "R4");
    bus_read(8'h04, 4'hF, 0, "R4 delay bit31");
    // R5 fault address read-only
    bus_write(8'h10, 32'h1234_5678, 4'hF, 0, "R5");
    bus_write(8'h14, 32'h9ABC_DEF0, 4'hF, 0, "R5");
    bus_read(8'h10, 4'hF, 0, "R5 fault0");
    bus_read(8'h14, 4'hF, 0, "R5 fault1");
    // R14 plain registers
    bus_write(8'h0C, 32'hA5A5_0001, 4'hF, 0, "R14");
    bus_write(8'h18, 32'h5A5A_0002, 4'hF, 0, "R14");
    bus_write(8'h1C, 32'h1111_2222, 4'hF, 0, "R14");
    bus_write(8'h20, 32'h3333_4444, 4'hF, 0, "R14");
    read_all("R14 independent storage");
    // R6 partial access
    bus_write(8'h0C, 32'hFFFF_FFFF, 4'h7, 0, "R6");
    bus_write(8'h00, 32'hFFFF_FFFF, 4'h1, 0, "R6");
    bus_read(8'h0C, 4'hF, 0, "R6 partial write ignored");
    bus_read(8'h00, 4'hF, 0, "R6 partial write ignored");
    bus_read(8'h0C, 4'h3, 0, "R6 partial read zero");
    // R8 fresh correctable capture, R10 masked irq
    err_pulse(0, 4'h5, 8'hC3, 36'hA_1234_5678, 0, 0, "R10 ce masked");
    bus_read(8'h08, 4'hF, 0, "R8 status");
    bus_read(8'h10, 4'hF, 0, "R8 fault0");
    bus_read(8'h14, 4'hF, 0, "R8 fault1");
    // R9 second capture, R10 ue irq
    err_pulse(1, 4'h9, 8'h11, 36'h3_DEAD_BEEF, 0, 0, "R10 ue irq");
    bus_read(8'h08, 4'hF, 0, "R9 status multi");
    bus_read(8'h10, 4'hF, 0, "R9 fault0 kept");
    bus_read(8'h14, 4'hF, 0, "R9 fault1 kept");
    // R7 status write clears irq
    bus_write(8'h08, 32'h0, 4'hF, 0, "R7 irq clear");
    bus_write(8'h08, 32'hCAFE_0000, 4'hF, 0, "R7");
    bus_read(8'h08, 4'hF, 0, "R7 status stored");
    bus_write(8'h08, 32'h0, 4'hF, 0, "R7");
    // R10 correctable with both enables
    bus_write(8'h00, 32'h3, 4'hF, 0, "R10");
    err_pulse(0, 4'h2, 8'h44, 36'h1_0000_0040, 0, 0, "R10 ce enabled");
    bus_write(8'h08, 32'h0, 4'hF, 0, "R7 clear");
    bus_write(8'h00, 32'h1, 4'hF, 0, "R10");
    err_pulse(0, 4'h2, 8'h44, 36'h1_0000_0080, 0, 0, "R10 ce half enabled");
    // R11 same-cycle write and capture
    err_pulse(1, 4'h7, 8'h99, 36'hF_0F0F_0F0F, 1, 32'h0000_0001, "R11 irq priority");
    bus_read(8'h08, 4'hF, 0, "R11 status merge");
    err_pulse(0, 4'h1, 8'h22, 36'h2_0000_1000, 1, 32'h0, "R11 fresh after write");
    bus_read(8'h08, 4'hF, 0, "R11 status");
    bus_read(8'h14, 4'hF, 0, "R11 fault1");
    // R13 diagnostic window
    for (int b = 0; b < 4; b++) bus_write(8'(b), 32'(8'h10 + b), 4'(1 << b), 1, "R13");
    for (int b = 0; b < 4; b++) bus_read(8'(b), 4'h1, 1, "R13 window read");
    bus_write(8'h02, 32'hEE, 4'h3, 1, "R13 two lanes");
    bus_read(8'h02, 4'h1, 1, "R13 multi-lane write ignored");
    bus_read(8'h02, 4'hF, 1, "R13 multi-lane read zero");
    // R12 soft reset retention
    bus_write(8'h00, 32'hFFFF_FFFF, 4'hF, 0, "R12");
    bus_write(8'h04, 32'h1234, 4'hF, 0, "R12");
    bus_write(8'h20, 32'h77, 4'hF, 0, "R12");
    err_pulse(1, 4'h3, 8'h55, 36'h4_0000_0004, 0, 0, "R12");
    soft_reset("R12 irq cleared");
    read_all("R12 after soft reset");
    for (int b = 0; b < 4; b++) bus_read(8'(b), 4'h2, 1, "R12 window kept");
    // random phase
    for (int n = 0; n < 1500; n++) begin
      int op;
      logic [31:0] r;
      op = int'($urandom % 16);
      r  = $urandom;
      case (op)
        0, 1, 2, 3: bus_write({4'($urandom % 12), 2'b00, 2'b00}[7:0] >> 0, r, 4'hF, 0, "R3 R14 random write");
        4, 5, 6, 7: bus_read(8'(($urandom % 12) * 4), 4'hF, 0, "R2 random read");
        8:  bus_write(8'(($urandom % 9) * 4), r, 4'($urandom), 0, "R6 random be");
        9, 10: err_pulse(1'($urandom), 4'($urandom), 8'($urandom), {4'($urandom), 32'($urandom)},
                         1'(($urandom % 4) == 0), 32'($urandom) & 32'h0001_0009, "R10 random capture");
        11: bus_write(8'h08, (($urandom % 2) == 0) ? 32'h0 : r, 4'hF, 0, "R7 random clear");
        12: bus_write(8'($urandom % 4), r, 4'(1 << ($urandom % 4)), 1, "R13 random diag");
        13: bus_read(8'($urandom % 4), 4'($urandom), 1, "R13 random diag read");
        14: bus_read(8'h08, 4'hF, 0, "R9 random status");
        default: if (($urandom % 8) == 0) soft_reset("R12 random"); else bus_read(8'h00, 4'hF, 0, "R3 random enable");
      endcase
    end
    read_all("R2 final");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule